// File: doc/BRIEF.md
# Station ID swizzle and address denormalizer

This block turns a normalized channel address back into a system physical address. It widens the address by opening zero-filled gaps at fixed interleave positions starting at bit 8. It then fills those gaps with a coherent station ID. The ID is built from the physical station instance number, the node ID and a set of configured fabric-ID fields, and its bits are reordered before insertion. Each request takes one cycle to enter. The result, or an error indication, leaves the block exactly two clock cycles later.

The channel count is given as its base-2 logarithm (3, 4 or 5 for 8, 16 or 32 channels). The die count is given the same way (0, 1 or 2 for 1, 2 or 4 dies). Any request that cannot be translated returns an all-ones address with the error output raised.

Top module: `stn_denorm`

## Requirements
- R1: When `intlv_pos` is not 8, the result carries `err`=1 and `sys_addr` is all ones.
- R2: When `inst_id` is 32 or more, the result carries `err`=1 and `sys_addr` is all ones.
- R3: A `chan_log2` outside 3..5 or a `die_log2` above 2 gives `err`=1 and an all-ones `sys_addr`.
- R4: min(`chan_log2`, 4) channel gap bits are opened at bit 8. Every input bit at or above 8 moves up by that count, and the opened bits are zero before the ID is inserted.
- R5: `die_log2` die gap bits are opened at bit 12 after the channel gap. Bits at and above 12 of the intermediate address move up by that count.
- R6: With `chan_log2`=5 one more gap bit is opened at bit 14, after the die gap.
- R7: `sys_addr[7:0]` always equals `norm_addr[7:0]` for a request without error.
- R8: The logical fabric ID is the table value for `inst_id` ORed with `node_id` shifted left by `node_shift`, truncated to the fabric-ID width. The table maps instances 0..31 to 12,13,14,15, 8,9,10,11, 4,5,6,7, 0,1,2,3, 28,29,30,31, 24,25,26,27, 20,21,22,23, 16,17,18,19.
- R9: `base_fid` is subtracted from the logical fabric ID, modulo 2^FID_W. The die ID is bits [1:0] of ((difference AND `die_mask`) >> `die_shift`).
- R10: The 7-bit station ID is {difference[4], die[1:0], difference[3:0]}. ID bit k is written to address bit 8+k wherever that position is an opened gap.
- R11: `out_valid` follows `in_valid` by exactly two cycles. `err` is 0 whenever `out_valid` is 0, and 0 for every request that meets none of R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| norm_addr | input | ADDR_W | Normalized address |
| chan_log2 | input | 3 | log2 of interleaved channel count (3..5) |
| die_log2 | input | 2 | log2 of interleaved die count (0..2) |
| intlv_pos | input | POS_W | Interleave start bit; must be 8 |
| inst_id | input | INST_W | Physical station instance number |
| node_id | input | NODE_W | Node ID |
| node_shift | input | SH_W | Left shift applied to node_id |
| base_fid | input | FID_W | Base destination fabric ID |
| die_mask | input | FID_W | Mask selecting the die field |
| die_shift | input | SH_W | Right shift applied to the die field |
| out_valid | output | 1 | Result present this cycle |
| sys_addr | output | ADDR_W | Denormalized system address |
| err | output | 1 | Request could not be translated |

## Verification
A wrong gap count or gap position appears as high address bits displaced by one or more places. The gap bits themselves then hold station-ID bits that belong to a different position, and all of this shows in the same result that is two cycles after the request. Errors in the table, the subtraction or the die extraction show only in bits 8 to 14. Each instance, node shift, base and mask pattern is therefore compared against an independent bit-walking model. A pipeline stage that is dropped or doubled moves `out_valid` by a cycle. It also mixes the fields of consecutive requests, which the back-to-back stream detects on its next result.

// File: rtl/denorm_pkg.sv
// Package: shared constants and helpers for the station-ID denormalizer.
// Assumes the fixed layout with channel gaps from bit 8, die gaps from bit 12
// and the extra channel gap at bit 14.
package denorm_pkg;
    localparam int GAP_BASE  = 8;              // required interleave start bit
    localparam int CH_MAX    = 4;              // channel bits below the die field
    localparam int DIE_POS   = GAP_BASE + CH_MAX;
    localparam int XTRA_POS  = GAP_BASE + 6;   // extra channel bit for 32 channels
    localparam int ID_W      = 7;              // swizzled station ID width
    localparam int NUM_STN   = 32;             // entries in the station table
    localparam int STN_IDX_W = $clog2(NUM_STN);

    typedef logic [ID_W-1:0] stn_id_t;

    // Physical-to-logical station map: groups of four are reversed inside each half.
    function automatic logic [STN_IDX_W-1:0] phys_to_log(input logic [STN_IDX_W-1:0] phys);
        return {phys[4], ~phys[3:2], phys[1:0]};
    endfunction
endpackage

// File: rtl/denorm_stn_swizzle.sv
// Module: builds the swizzled 7-bit station ID from the instance number.
// Assumes inst_id indexes a 32-entry fixed table; larger values are flagged.
module denorm_stn_swizzle
    import denorm_pkg::*;
#(
    parameter int FID_W  = 12,
    parameter int NODE_W = 4,
    parameter int INST_W = 6,
    parameter int SH_W   = 4
) (
    input  logic [INST_W-1:0] inst_id,
    input  logic [NODE_W-1:0] node_id,
    input  logic [SH_W-1:0]   node_shift,
    input  logic [FID_W-1:0]  base_fid,
    input  logic [FID_W-1:0]  die_mask,
    input  logic [SH_W-1:0]   die_shift,
    output stn_id_t           stn_id,
    output logic              inst_err
);
    logic [FID_W-1:0] log_fid;
    logic [FID_W-1:0] rel_fid;
    logic [FID_W-1:0] die_field;
    logic [1:0]       die_id;

    // Range check on the instance number.
    always_comb begin
        inst_err = (32'(inst_id) >= NUM_STN);
    end

    // Logical fabric ID, base removal and die extraction.
    always_comb begin
        log_fid   = FID_W'(phys_to_log(inst_id[STN_IDX_W-1:0]))
                  | (FID_W'(node_id) << node_shift);
        rel_fid   = log_fid - base_fid;
        die_field = (rel_fid & die_mask) >> die_shift;
        die_id    = die_field[1:0];
    end

    // Swizzle: stack bit on top, die in the middle, channel at the bottom.
    always_comb begin
        stn_id = {rel_fid[4], die_id, rel_fid[3:0]};
    end
endmodule

// File: rtl/denorm_gap_opener.sv
// Module: widens the normalized address by opening the channel, die and extra
// gaps in that order, and reports which of bits 8..14 are gaps.
// Assumes the count codes are checked here; invalid codes raise cnt_err.
module denorm_gap_opener
    import denorm_pkg::*;
#(
    parameter int ADDR_W = 52
) (
    input  logic [ADDR_W-1:0] norm_addr,
    input  logic [2:0]        chan_log2,
    input  logic [1:0]        die_log2,
    output logic [ADDR_W-1:0] wide_addr,
    output logic [ID_W-1:0]   gap_mask,
    output logic              cnt_err
);
    logic [2:0]        ch_bits;
    logic              xtra;
    logic [ADDR_W-1:0] after_ch;
    logic [ADDR_W-1:0] after_die;

    // Shift bits at and above pos up by cnt, keeping the lower bits.
    function automatic logic [ADDR_W-1:0] open_gap(input logic [ADDR_W-1:0] a,
                                                   input int unsigned pos,
                                                   input int unsigned cnt);
        logic [ADDR_W-1:0] keep;
        keep = (ADDR_W'(1) << pos) - ADDR_W'(1);
        return ((a >> pos) << (pos + cnt)) | (a & keep);
    endfunction

    // Decode the count codes.
    always_comb begin
        cnt_err = (chan_log2 < 3'd3) || (chan_log2 > 3'd5) || (die_log2 > 2'd2);
        ch_bits = (chan_log2 > 3'(CH_MAX)) ? 3'(CH_MAX) : chan_log2;
        xtra    = (chan_log2 > 3'(CH_MAX));
    end

    // Open the three gaps in sequence.
    always_comb begin
        after_ch  = open_gap(norm_addr, GAP_BASE, 32'(ch_bits));
        after_die = open_gap(after_ch, DIE_POS, 32'(die_log2));
        wide_addr = xtra ? open_gap(after_die, XTRA_POS, 1) : after_die;
    end

    // Mark which of the ID positions are gaps.
    always_comb begin
        for (int k = 0; k < ID_W; k++) begin
            gap_mask[k] = (k < int'(ch_bits))
                       || ((k >= CH_MAX) && (k < CH_MAX + int'(die_log2)))
                       || ((k == XTRA_POS - GAP_BASE) && xtra);
        end
    end
endmodule

// File: rtl/denorm_id_insert.sv
// Module: writes station ID bit k into address bit GAP_BASE+k wherever that
// position is a gap; forces all ones on error.
module denorm_id_insert
    import denorm_pkg::*;
#(
    parameter int ADDR_W = 52
) (
    input  logic [ADDR_W-1:0] wide_addr,
    input  logic [ID_W-1:0]   gap_mask,
    input  stn_id_t           stn_id,
    input  logic              fail,
    output logic [ADDR_W-1:0] sys_addr
);
    logic [ADDR_W-1:0] mask_full;
    logic [ADDR_W-1:0] id_full;

    // Place the mask and ID at the gap base.
    always_comb begin
        mask_full = ADDR_W'(gap_mask) << GAP_BASE;
        id_full   = ADDR_W'(stn_id) << GAP_BASE;
    end

    // Merge or force the error value.
    always_comb begin
        if (fail) sys_addr = '1;
        else      sys_addr = (wide_addr & ~mask_full) | (id_full & mask_full);
    end
endmodule

// File: rtl/stn_denorm.sv
// Module: two-stage station-ID denormalizer. Stage 1 opens gaps and builds the
// swizzled ID; stage 2 inserts the ID and registers the result.
// Assumes one request per cycle at most, no backpressure.
module stn_denorm
    import denorm_pkg::*;
#(
    parameter int ADDR_W = 52,
    parameter int FID_W  = 12,
    parameter int NODE_W = 4,
    parameter int INST_W = 6,
    parameter int POS_W  = 6,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] norm_addr,
    input  logic [2:0]        chan_log2,
    input  logic [1:0]        die_log2,
    input  logic [POS_W-1:0]  intlv_pos,
    input  logic [INST_W-1:0] inst_id,
    input  logic [NODE_W-1:0] node_id,
    input  logic [SH_W-1:0]   node_shift,
    input  logic [FID_W-1:0]  base_fid,
    input  logic [FID_W-1:0]  die_mask,
    input  logic [SH_W-1:0]   die_shift,
    output logic              out_valid,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              err
);
    stn_id_t           id_c;
    logic              inst_err_c;
    logic [ADDR_W-1:0] wide_c;
    logic [ID_W-1:0]   mask_c;
    logic              cnt_err_c;
    logic              pos_err_c;

    logic              s1_valid;
    logic [ADDR_W-1:0] s1_addr;
    logic [ID_W-1:0]   s1_mask;
    stn_id_t           s1_id;
    logic              s1_fail;
    logic [ADDR_W-1:0] merged_c;

    denorm_stn_swizzle #(
        .FID_W(FID_W), .NODE_W(NODE_W), .INST_W(INST_W), .SH_W(SH_W)
    ) u_swz (
        .inst_id(inst_id), .node_id(node_id), .node_shift(node_shift),
        .base_fid(base_fid), .die_mask(die_mask), .die_shift(die_shift),
        .stn_id(id_c), .inst_err(inst_err_c)
    );

    denorm_gap_opener #(.ADDR_W(ADDR_W)) u_gap (
        .norm_addr(norm_addr), .chan_log2(chan_log2), .die_log2(die_log2),
        .wide_addr(wide_c), .gap_mask(mask_c), .cnt_err(cnt_err_c)
    );

    // Interleave start must sit at the fixed gap base.
    always_comb begin
        pos_err_c = (32'(intlv_pos) != GAP_BASE);
    end

    // Stage 1 registers: widened address, gap mask, ID and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_addr  <= '0;
            s1_mask  <= '0;
            s1_id    <= '0;
            s1_fail  <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_addr  <= wide_c;
            s1_mask  <= mask_c;
            s1_id    <= id_c;
            s1_fail  <= in_valid && (pos_err_c || inst_err_c || cnt_err_c);
        end
    end

    denorm_id_insert #(.ADDR_W(ADDR_W)) u_ins (
        .wide_addr(s1_addr), .gap_mask(s1_mask), .stn_id(s1_id),
        .fail(s1_fail), .sys_addr(merged_c)
    );

    // Stage 2 registers: final address and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sys_addr  <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            sys_addr  <= merged_c;
            err       <= s1_valid && s1_fail;
        end
    end
endmodule

// File: rtl/stn_denorm_chk.sv
// Module: assertion checker for stn_denorm, attached by bind.
module stn_denorm_chk #(
    parameter int ADDR_W = 52,
    parameter int INST_W = 6,
    parameter int POS_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] norm_addr,
    input logic [2:0]        chan_log2,
    input logic [1:0]        die_log2,
    input logic [POS_W-1:0]  intlv_pos,
    input logic [INST_W-1:0] inst_id,
    input logic              out_valid,
    input logic [ADDR_W-1:0] sys_addr,
    input logic              err
);
    logic req_ok;

    // Request free of every error condition.
    always_comb begin
        req_ok = (32'(intlv_pos) == 8) && (32'(inst_id) < 32)
              && (chan_log2 >= 3'd3) && (chan_log2 <= 3'd5) && (die_log2 <= 2'd2);
    end

    AST_BAD_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (32'(intlv_pos) != 8)) |-> ##2 (out_valid && err)); // R1
    AST_BAD_INST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (32'(inst_id) >= 32)) |-> ##2 (out_valid && err)); // R2
    AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err) |-> (sys_addr == '1)); // R3
    AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_ok) |-> ##2 (sys_addr[7:0] == $past(norm_addr[7:0], 2))); // R7
    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R11
    AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R11
    AST_IDLE_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !err); // R11
    AST_GOOD_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_ok) |-> ##2 !err); // R11
endmodule

bind stn_denorm stn_denorm_chk #(
    .ADDR_W(ADDR_W), .INST_W(INST_W), .POS_W(POS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .norm_addr(norm_addr),
    .chan_log2(chan_log2), .die_log2(die_log2), .intlv_pos(intlv_pos),
    .inst_id(inst_id), .out_valid(out_valid), .sys_addr(sys_addr), .err(err)
);

// File: tb/stn_denorm_tb.sv
module stn_denorm_tb;
    localparam int ADDR_W = 52;
    localparam int FID_W  = 12;
    localparam int NODE_W = 4;
    localparam int INST_W = 6;
    localparam int POS_W  = 6;
    localparam int SH_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] norm_addr = '0;
    logic [2:0]        chan_log2 = 3'd3;
    logic [1:0]        die_log2 = 2'd0;
    logic [POS_W-1:0]  intlv_pos = 6'd8;
    logic [INST_W-1:0] inst_id = '0;
    logic [NODE_W-1:0] node_id = '0;
    logic [SH_W-1:0]   node_shift = '0;
    logic [FID_W-1:0]  base_fid = '0;
    logic [FID_W-1:0]  die_mask = '0;
    logic [SH_W-1:0]   die_shift = '0;
    logic              out_valid;
    logic [ADDR_W-1:0] sys_addr;
    logic              err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    int STN_TBL [32] = '{12, 13, 14, 15, 8, 9, 10, 11, 4, 5, 6, 7, 0, 1, 2, 3,
                         28, 29, 30, 31, 24, 25, 26, 27, 20, 21, 22, 23, 16, 17, 18, 19};

    stn_denorm #(
        .ADDR_W(ADDR_W), .FID_W(FID_W), .NODE_W(NODE_W),
        .INST_W(INST_W), .POS_W(POS_W), .SH_W(SH_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .norm_addr(norm_addr),
        .chan_log2(chan_log2), .die_log2(die_log2), .intlv_pos(intlv_pos),
        .inst_id(inst_id), .node_id(node_id), .node_shift(node_shift),
        .base_fid(base_fid), .die_mask(die_mask), .die_shift(die_shift),
        .out_valid(out_valid), .sys_addr(sys_addr), .err(err)
    );

    always #10 clk = ~clk;

    // Reference model: returns {err, address}, built by walking output bits.
    function automatic logic [ADDR_W:0] model();
        logic [FID_W-1:0] fid;
        logic [FID_W-1:0] dfield;
        logic [6:0]       id;
        logic [6:0]       gm;
        logic [ADDR_W-1:0] res;
        int nc;
        int src;
        if (intlv_pos != 6'd8 || int'(inst_id) >= 32 || chan_log2 < 3 || chan_log2 > 5
            || die_log2 > 2)
            return {1'b1, {ADDR_W{1'b1}}};
        fid    = FID_W'(STN_TBL[inst_id[4:0]]) | (FID_W'(node_id) << node_shift);
        fid    = fid - base_fid;
        dfield = (fid & die_mask) >> die_shift;
        id     = {fid[4], dfield[1:0], fid[3:0]};
        nc     = (chan_log2 > 4) ? 4 : int'(chan_log2);
        gm     = '0;
        for (int k = 0; k < nc; k++) gm[k] = 1'b1;
        for (int k = 0; k < int'(die_log2); k++) gm[4 + k] = 1'b1;
        if (chan_log2 == 5) gm[6] = 1'b1;
        src = 0;
        res = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i >= 8 && i <= 14 && gm[i - 8]) res[i] = id[i - 8];
            else begin
                res[i] = norm_addr[src];
                src++;
            end
        end
        return {1'b0, res};
    endfunction

    task automatic chk(input string req, input logic [ADDR_W:0] act, input logic [ADDR_W:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request, then compare the result two cycles later.
    task automatic one_req(input string req);
        logic [ADDR_W:0] exp;
        @(negedge clk);
        in_valid = 1'b1;
        exp = model();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(req, {out_valid, 51'b0}, {1'b1, 51'b0});
        chk(req, {err, sys_addr}, exp);
    endtask

    task automatic set_cfg(input logic [2:0] cl, input logic [1:0] dl, input logic [INST_W-1:0] inst,
                           input logic [NODE_W-1:0] nd, input logic [SH_W-1:0] nsh,
                           input logic [FID_W-1:0] base, input logic [FID_W-1:0] dm,
                           input logic [SH_W-1:0] dsh);
        chan_log2 = cl; die_log2 = dl; inst_id = inst; node_id = nd;
        node_shift = nsh; base_fid = base; die_mask = dm; die_shift = dsh;
        intlv_pos = 6'd8;
    endtask

    task automatic t_reset();
        chk("R11 reset", {err, sys_addr}, '0);
        chk("R11 reset valid", {51'b0, out_valid, 1'b0}, '0);
    endtask

    task automatic t_chan8();
        set_cfg(3'd3, 2'd0, 6'd5, 4'd0, 4'd0, 12'd0, 12'h060, 4'd5);
        norm_addr = 52'h0_1234_5678_9ABC;
        one_req("R4 R7 8ch");
        norm_addr = 52'hF_FFFF_FFFF_FFFF;
        one_req("R4 R10 8ch ones");
    endtask

    task automatic t_chan16_dies();
        set_cfg(3'd4, 2'd1, 6'd17, 4'd0, 4'd0, 12'd0, 12'h060, 4'd5);
        norm_addr = 52'h0_0000_0000_0FFF;
        one_req("R5 16ch 2die");
        set_cfg(3'd4, 2'd2, 6'd30, 4'd0, 4'd0, 12'd0, 12'h060, 4'd5);
        norm_addr = 52'h0_0ABC_DEF0_1357;
        one_req("R5 16ch 4die");
    endtask

    task automatic t_chan32();
        set_cfg(3'd5, 2'd2, 6'd31, 4'd0, 4'd0, 12'd0, 12'h060, 4'd5);
        norm_addr = 52'h0_0000_0000_FFFF;
        one_req("R6 32ch 4die");
        set_cfg(3'd5, 2'd1, 6'd19, 4'd0, 4'd0, 12'd0, 12'h060, 4'd5);
        norm_addr = 52'h0_0000_0012_3456;
        one_req("R6 32ch 2die");
        set_cfg(3'd5, 2'd0, 6'd16, 4'd0, 4'd0, 12'd0, 12'h060, 4'd5);
        norm_addr = 52'h0_0000_00FF_00FF;
        one_req("R6 32ch 1die");
    endtask

    task automatic t_fabric();
        set_cfg(3'd5, 2'd2, 6'd9, 4'd3, 4'd5, 12'h040, 12'h060, 4'd5);
        norm_addr = 52'h0_0000_0000_0000;
        one_req("R8 R9 node shift base");
        set_cfg(3'd5, 2'd2, 6'd0, 4'd1, 4'd7, 12'h00D, 12'h300, 4'd8);
        one_req("R9 mask shift wrap");
        set_cfg(3'd4, 2'd2, 6'd22, 4'd2, 4'd6, 12'h03, 12'h0C0, 4'd6);
        one_req("R8 R10 node die");
    endtask

    task automatic t_errors();
        set_cfg(3'd4, 2'd1, 6'd3, 4'd0, 4'd0, 12'd0, 12'h060, 4'd5);
        norm_addr = 52'h0_0000_0000_1234;
        intlv_pos = 6'd9;
        one_req("R1 pos 9");
        intlv_pos = 6'd0;
        one_req("R1 pos 0");
        intlv_pos = 6'd8;
        inst_id = 6'd32;
        one_req("R2 inst 32");
        inst_id = 6'd63;
        one_req("R2 inst 63");
        inst_id = 6'd3;
        chan_log2 = 3'd2;
        one_req("R3 chan code 2");
        chan_log2 = 3'd6;
        one_req("R3 chan code 6");
        chan_log2 = 3'd4;
        die_log2 = 2'd3;
        one_req("R3 die code 3");
        die_log2 = 2'd1;
        one_req("R11 good after error");
    endtask

    task automatic t_sweep();
        for (int n = 0; n < 64; n++) begin
            set_cfg(3'(3 + (n % 3)), 2'((n / 3) % 3), 6'(n % 32), 4'($urandom),
                    4'($urandom_range(0, 7)), 12'($urandom), 12'($urandom), 4'($urandom_range(0, 9)));
            norm_addr = {20'($urandom), 32'($urandom)};
            one_req("R8 R10 sweep");
        end
    endtask

    // Back-to-back stream: results appear two cycles after each request.
    task automatic t_stream();
        logic [ADDR_W:0] exp_q [3];
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (c >= 2 && c < 5) begin
                chk("R11 stream valid", {51'b0, out_valid, 1'b0}, {51'b0, 1'b1, 1'b0});
                chk("R11 stream data", {err, sys_addr}, exp_q[c - 2]);
            end
            if (c == 5) chk("R11 stream idle", {51'b0, out_valid, err}, '0);
            if (c < 3) begin
                set_cfg(3'(3 + c), 2'(c), 6'(7 * c + 1), 4'(c), 4'd5, 12'd0, 12'h060, 4'd5);
                intlv_pos = (c == 1) ? 6'd4 : 6'd8;
                norm_addr = 52'h0_0000_0000_ABCD << (4 * c);
                exp_q[c] = model();
                in_valid = 1'b1;
            end else in_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chan8();
        t_chan16_dies();
        t_chan32();
        t_fabric();
        t_errors();
        t_stream();
        t_sweep();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule